// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block is the engine a small microcontroller uses to reprogram its own program memory. The CPU writes a command code into a control register, which arms the engine for a short window. It then issues a store strobe or a load strobe that carries a byte address and, for stores, a 16-bit data word. Store strobes perform these operations:

- fill one word of a temporary page buffer
- erase the page that holds the address
- copy the buffer into that page
- program boot lock bits

Load strobes return a byte of program memory. Under the lock/info command a load strobe returns a lock or fuse byte instead, and under the signature command it returns a signature-row byte.

The state machine has three states. IDLE waits for a valid command write. ARMED holds one command for at most `ARM_WINDOW` clocks. BUSY runs an erase or page write for `BUSY_CYCLES` clocks.

The transitions are as follows:

- arm: IDLE to ARMED on a valid command write.
- re-arm or cancel: a command write in ARMED either loads the new command or returns the engine to IDLE.
- consume: any strobe in ARMED leaves ARMED. It goes to BUSY for an erase or write store, and to IDLE otherwise.
- expire: ARMED returns to IDLE when the window runs out.
- complete: BUSY returns to IDLE when its count ends, and the page change is committed on that edge.

A chip-erase input forces IDLE from any state. It also restores every lock bit, the page buffer and the whole program array to all ones.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset, `busy` is 0 and `rdata` is 0x00. Every program byte reads 0xFF and the lock byte reads 0xFF.
- R2: A strobe is accepted when it is sampled on any of the four clock edges after the edge that took the command write. A strobe on the fifth edge or later finds the engine disarmed and has no effect.
- R3: The command codes are fill 0x01, erase 0x03, write 0x05, lock-set/info-read 0x09 and signature-read 0x21. Any other code does not arm the engine and cancels a pending arm. One strobe consumes the arm. A store strobe with no arm, or with a non-store arm, changes nothing.
- R4: A fill stores the word at buffer slot address[3:1]. In program memory the low byte appears at the even address and the high byte at the following odd address.
- R5: A page write copies the whole buffer into page address[6:4] when busy ends. The buffer then reads back as all ones.
- R6: A page erase sets every byte of page address[6:4] to 0xFF, whichever byte of that page was addressed.
- R7: An accepted erase or write holds `busy` high for exactly BUSY_CYCLES clocks (6 by default). Command writes and strobes made during that time are ignored.
- R8: A lock-set store clears lock bit n, for n in 5..2, when data bit n is 0. Lock bits 7, 6, 1 and 0 stay 1. No lock bit ever returns to 1 without chip erase. The address has no effect.
- R9: A load under the info-read command returns, for address[1:0] = 0, 1, 2 and 3, the low fuse byte (0x62), the lock byte, the extended fuse byte (0xFF) and the high fuse byte (0xD9).
- R10: A load under the signature command returns byte ((i*37) mod 256) XOR 0xA5, where i is address[4:0].
- R11: A load with no arm, or with an arm other than info-read or signature, returns the program-array byte at the address. This still holds after lock bits have been programmed.
- R12: A one-cycle `chip_erase` pulse sets the lock byte, the buffer and all program bytes to 0xFF, and aborts any arm or busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_erase | input | 1 | Full erase including lock bits |
| ctl_we | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Command code |
| spm_stb | input | 1 | Store strobe |
| lpm_stb | input | 1 | Load strobe |
| addr | input | 7 | Byte address |
| wdata | input | 16 | Store data word |
| rdata | output | 8 | Load result, registered |
| busy | output | 1 | Erase or write in progress |

## Verification
On every cycle the assertions check four things. The arm counter never leaves its window. Busy only starts after a store strobe. Lock bits never rise except through chip erase, and the fixed lock bits stay at one. The buffer or erased page is all ones right after a commit. The bench scenarios show the rest: the exact fifth-edge cutoff, stimulus ignored during busy, byte ordering of fills, correct address decoding for fuse and signature reads, and the contents of program memory after mixed random sequences.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_FILL, CMD_ERASE, CMD_WRITE, CMD_LOCK, CMD_SIG
    } cmd_e;

    typedef enum logic [1:0] {
        S_IDLE, S_ARMED, S_BUSY
    } state_e;

    localparam logic [7:0] CODE_FILL  = 8'h01;
    localparam logic [7:0] CODE_ERASE = 8'h03;
    localparam logic [7:0] CODE_WRITE = 8'h05;
    localparam logic [7:0] CODE_LOCK  = 8'h09;
    localparam logic [7:0] CODE_SIG   = 8'h21;

    function automatic cmd_e decode_cmd(input logic [7:0] v);
        case (v)
            CODE_FILL:  return CMD_FILL;
            CODE_ERASE: return CMD_ERASE;
            CODE_WRITE: return CMD_WRITE;
            CODE_LOCK:  return CMD_LOCK;
            CODE_SIG:   return CMD_SIG;
            default:    return CMD_NONE;
        endcase
    endfunction

    function automatic logic [7:0] sig_byte(input logic [4:0] idx);
        logic [7:0] prod;
        prod = {3'b000, idx} * 8'd37;
        return prod ^ 8'hA5;
    endfunction

endpackage

// File: rtl/sp_cmd_fsm.sv
module sp_cmd_fsm
    import selfprog_pkg::*;
#(
    parameter int ARM_WINDOW  = 4,
    parameter int BUSY_CYCLES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_erase,
    input  logic       ctl_we,
    input  logic [7:0] ctl_data,
    input  logic       spm_stb,
    input  logic       lpm_stb,
    output logic       busy,
    output logic       fill_en,
    output logic       lock_en,
    output logic       start_erase,
    output logic       start_write,
    output logic       commit_erase,
    output logic       commit_write,
    output logic       rd_plain,
    output logic       rd_info,
    output logic       rd_sig
);
    localparam int WIN_W = $clog2(ARM_WINDOW + 1);
    localparam int BC_W  = $clog2(BUSY_CYCLES + 1);

    state_e           state_q, state_d;
    cmd_e             cmd_q, cmd_d, dec_c;
    logic [WIN_W-1:0] win_q, win_d;
    logic [BC_W-1:0]  bcnt_q, bcnt_d;
    logic             wr_op_q, wr_op_d;
    logic             armed;

    always_comb dec_c = decode_cmd(ctl_data);

    always_comb begin
        state_d = state_q;
        cmd_d   = cmd_q;
        win_d   = win_q;
        bcnt_d  = bcnt_q;
        wr_op_d = wr_op_q;
        unique case (state_q)
            S_IDLE: begin
                if (ctl_we && dec_c != CMD_NONE) begin
                    state_d = S_ARMED;
                    cmd_d   = dec_c;
                    win_d   = WIN_W'(ARM_WINDOW);
                end
            end
            S_ARMED: begin
                if (spm_stb || lpm_stb) begin
                    if (spm_stb && (cmd_q == CMD_ERASE || cmd_q == CMD_WRITE)) begin
                        state_d = S_BUSY;
                        bcnt_d  = BC_W'(BUSY_CYCLES);
                        wr_op_d = (cmd_q == CMD_WRITE);
                    end else begin
                        state_d = S_IDLE;
                    end
                    cmd_d = CMD_NONE;
                end else if (ctl_we) begin
                    if (dec_c != CMD_NONE) begin
                        cmd_d = dec_c;
                        win_d = WIN_W'(ARM_WINDOW);
                    end else begin
                        state_d = S_IDLE;
                        cmd_d   = CMD_NONE;
                    end
                end else if (win_q == WIN_W'(1)) begin
                    state_d = S_IDLE;
                    cmd_d   = CMD_NONE;
                end else begin
                    win_d = win_q - WIN_W'(1);
                end
            end
            S_BUSY: begin
                if (bcnt_q == BC_W'(1)) state_d = S_IDLE;
                else                    bcnt_d  = bcnt_q - BC_W'(1);
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cmd_q   <= CMD_NONE;
            win_q   <= '0;
            bcnt_q  <= '0;
            wr_op_q <= 1'b0;
        end else if (chip_erase) begin
            state_q <= S_IDLE;
            cmd_q   <= CMD_NONE;
            win_q   <= '0;
            bcnt_q  <= '0;
            wr_op_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            win_q   <= win_d;
            bcnt_q  <= bcnt_d;
            wr_op_q <= wr_op_d;
        end
    end

    always_comb begin
        armed        = (state_q == S_ARMED);
        busy         = (state_q == S_BUSY);
        fill_en      = armed && spm_stb && cmd_q == CMD_FILL;
        lock_en      = armed && spm_stb && cmd_q == CMD_LOCK;
        start_erase  = armed && spm_stb && cmd_q == CMD_ERASE;
        start_write  = armed && spm_stb && cmd_q == CMD_WRITE;
        rd_info      = armed && !spm_stb && lpm_stb && cmd_q == CMD_LOCK;
        rd_sig       = armed && !spm_stb && lpm_stb && cmd_q == CMD_SIG;
        rd_plain     = !spm_stb && lpm_stb &&
                       (state_q == S_IDLE ||
                        (armed && cmd_q != CMD_LOCK && cmd_q != CMD_SIG));
        commit_erase = busy && bcnt_q == BC_W'(1) && !wr_op_q;
        commit_write = busy && bcnt_q == BC_W'(1) && wr_op_q;
    end

    // R2
    arm_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_ARMED |-> (win_q >= WIN_W'(1) && win_q <= WIN_W'(ARM_WINDOW)));

    // R7
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(spm_stb));

endmodule

// File: rtl/sp_flash_store.sv
module sp_flash_store #(
    parameter int PAGE_WORDS = 8,
    parameter int NUM_PAGES  = 8,
    localparam int WORD_IDX_W = $clog2(PAGE_WORDS),
    localparam int PAGE_IDX_W = $clog2(NUM_PAGES),
    localparam int ADDR_W     = 1 + WORD_IDX_W + PAGE_IDX_W,
    localparam int ROW_W      = PAGE_WORDS * 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_erase,
    input  logic              fill_en,
    input  logic              start_erase,
    input  logic              start_write,
    input  logic              commit_erase,
    input  logic              commit_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [7:0]        rd_byte
);
    logic [ROW_W-1:0]      buf_q;
    logic [PAGE_IDX_W-1:0] pend_q;
    logic [ROW_W-1:0]      page_flat [NUM_PAGES];
    logic [WORD_IDX_W-1:0] widx;
    logic [PAGE_IDX_W-1:0] pidx;
    logic [15:0]           rd_word;

    assign widx = addr[WORD_IDX_W:1];
    assign pidx = addr[ADDR_W-1:WORD_IDX_W+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    buf_q <= '1;
        else if (chip_erase)           buf_q <= '1;
        else if (commit_write)         buf_q <= '1;
        else if (fill_en)              buf_q[int'(widx)*16 +: 16] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          pend_q <= '0;
        else if (start_erase || start_write) pend_q <= pidx;
    end

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        logic [ROW_W-1:0] row_q;
        logic             hit;
        assign hit = (pend_q == PAGE_IDX_W'(p));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    row_q <= '1;
            else if (chip_erase)           row_q <= '1;
            else if (commit_erase && hit)  row_q <= '1;
            else if (commit_write && hit)  row_q <= buf_q;
        end
        assign page_flat[p] = row_q;
    end

    assign rd_word = page_flat[pidx][int'(widx)*16 +: 16];
    assign rd_byte = addr[0] ? rd_word[15:8] : rd_word[7:0];

    // R5
    buf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_write && !chip_erase |=> buf_q == '1);

    // R6
    erase_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_erase && !chip_erase |=> page_flat[$past(pend_q)] == '1);

endmodule

// File: rtl/sp_info_bank.sv
module sp_info_bank
    import selfprog_pkg::*;
#(
    parameter logic [7:0] FUSE_LO = 8'h62,
    parameter logic [7:0] FUSE_HI = 8'hD9,
    parameter logic [7:0] FUSE_EX = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_erase,
    input  logic       lock_en,
    input  logic [7:0] lock_data,
    input  logic [1:0] info_sel,
    input  logic [4:0] sig_idx,
    output logic [7:0] info_byte,
    output logic [7:0] sig_out
);
    logic [7:0] lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          lock_q <= 8'hFF;
        else if (chip_erase) lock_q <= 8'hFF;
        else if (lock_en)    lock_q <= lock_q & {2'b11, lock_data[5:2], 2'b11};
    end

    always_comb begin
        unique case (info_sel)
            2'd0: info_byte = FUSE_LO;
            2'd1: info_byte = lock_q;
            2'd2: info_byte = FUSE_EX;
            2'd3: info_byte = FUSE_HI;
            default: info_byte = 8'hFF;
        endcase
    end

    assign sig_out = sig_byte(sig_idx);

    // R8
    lock_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_erase |=> ((lock_q & ~$past(lock_q)) == 8'h00));

    // R8
    lock_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[7:6] == 2'b11 && lock_q[1:0] == 2'b11);

    // R12
    erase_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase |=> lock_q == 8'hFF);

endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl #(
    parameter int         PAGE_WORDS  = 8,
    parameter int         NUM_PAGES   = 8,
    parameter int         ARM_WINDOW  = 4,
    parameter int         BUSY_CYCLES = 6,
    parameter logic [7:0] FUSE_LO     = 8'h62,
    parameter logic [7:0] FUSE_HI     = 8'hD9,
    parameter logic [7:0] FUSE_EX     = 8'hFF,
    localparam int        ADDR_W      = 1 + $clog2(PAGE_WORDS) + $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_erase,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_data,
    input  logic              spm_stb,
    input  logic              lpm_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [7:0]        rdata,
    output logic              busy
);
    logic fill_en, lock_en, start_erase, start_write;
    logic commit_erase, commit_write, rd_plain, rd_info, rd_sig;
    logic [7:0] arr_byte, info_byte, sig_out;

    sp_cmd_fsm #(.ARM_WINDOW(ARM_WINDOW), .BUSY_CYCLES(BUSY_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .chip_erase(chip_erase),
        .ctl_we(ctl_we), .ctl_data(ctl_data),
        .spm_stb(spm_stb), .lpm_stb(lpm_stb), .busy(busy),
        .fill_en(fill_en), .lock_en(lock_en),
        .start_erase(start_erase), .start_write(start_write),
        .commit_erase(commit_erase), .commit_write(commit_write),
        .rd_plain(rd_plain), .rd_info(rd_info), .rd_sig(rd_sig)
    );

    sp_flash_store #(.PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES)) u_store (
        .clk(clk), .rst_n(rst_n), .chip_erase(chip_erase),
        .fill_en(fill_en), .start_erase(start_erase), .start_write(start_write),
        .commit_erase(commit_erase), .commit_write(commit_write),
        .addr(addr), .wdata(wdata), .rd_byte(arr_byte)
    );

    sp_info_bank #(.FUSE_LO(FUSE_LO), .FUSE_HI(FUSE_HI), .FUSE_EX(FUSE_EX)) u_info (
        .clk(clk), .rst_n(rst_n), .chip_erase(chip_erase),
        .lock_en(lock_en), .lock_data(wdata[7:0]),
        .info_sel(addr[1:0]), .sig_idx(addr[4:0]),
        .info_byte(info_byte), .sig_out(sig_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rdata <= 8'h00;
        else if (rd_plain) rdata <= arr_byte;
        else if (rd_info)  rdata <= info_byte;
        else if (rd_sig)   rdata <= sig_out;
    end

endmodule

// File: tb/selfprog_ctrl_test.sv
module selfprog_ctrl_test;
    localparam int NB = 6;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        chip_erase = 0, ctl_we = 0, spm_stb = 0, lpm_stb = 0;
    logic [7:0]  ctl_data = 0;
    logic [6:0]  addr = 0;
    logic [15:0] wdata = 0;
    logic [7:0]  rdata;
    logic        busy;

    int n_cmp = 0, n_bad = 0;
    logic [15:0] m_mem [64];
    logic [15:0] m_buf [8];
    logic [7:0]  m_lock;

    always #5 clk = ~clk;

    selfprog_ctrl uut (.clk(clk), .rst_n(rst_n), .chip_erase(chip_erase),
        .ctl_we(ctl_we), .ctl_data(ctl_data), .spm_stb(spm_stb), .lpm_stb(lpm_stb),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy));

    function automatic logic [7:0] exp_sig(input int i);
        logic [7:0] p;
        p = 8'((i * 37) % 256);
        return p ^ 8'hA5;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [6:0] a);
        logic [15:0] w;
        w = m_mem[a[6:1]];
        return a[0] ? w[15:8] : w[7:0];
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic arm(input logic [7:0] code);
        ctl_we = 1; ctl_data = code;
        @(negedge clk);
        ctl_we = 0;
    endtask

    task automatic spm(input logic [6:0] a, input logic [15:0] d);
        spm_stb = 1; addr = a; wdata = d;
        @(negedge clk);
        spm_stb = 0;
    endtask

    task automatic lpm(input logic [6:0] a, output logic [7:0] v);
        lpm_stb = 1; addr = a;
        @(negedge clk);
        lpm_stb = 0;
        v = rdata;
    endtask

    task automatic drain();
        while (busy) @(negedge clk);
    endtask

    task automatic do_fill(input logic [6:0] a, input logic [15:0] d);
        arm(8'h01); spm(a, d);
        m_buf[a[3:1]] = d;
    endtask

    task automatic do_busy_op(input logic [7:0] code, input logic [6:0] a, input bit chk);
        int cnt;
        arm(code); spm(a, 16'h0);
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        if (chk) check("R7 busy length", 16'(cnt), 16'(NB));
        for (int w = 0; w < 8; w++) begin
            m_mem[{a[6:4], 3'(w)}] = (code == 8'h05) ? m_buf[w] : 16'hFFFF;
        end
        if (code == 8'h05) for (int w = 0; w < 8; w++) m_buf[w] = 16'hFFFF;
    endtask

    task automatic check_page(input string tag, input logic [2:0] pg);
        logic [7:0] v;
        for (int b = 0; b < 16; b++) begin
            lpm({pg, 4'(b)}, v);
            check(tag, {8'h0, v}, {8'h0, exp_byte({pg, 4'(b)})});
        end
    endtask

    task automatic info(input logic [7:0] code, input logic [6:0] a, output logic [7:0] v);
        arm(code); lpm(a, v);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF;
        for (int i = 0; i < 8; i++) m_buf[i] = 16'hFFFF;
        m_lock = 8'hFF;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", {15'h0, busy}, 16'h0);
        check("R1 rdata", {8'h0, rdata}, 16'h0);
        lpm(7'h15, v); check("R1 array", {8'h0, v}, 16'hFF);
        info(8'h09, 7'h01, v); check("R1 lock", {8'h0, v}, 16'hFF);

        // R4 R5 fill then write page 2, byte order
        do_fill(7'h20, 16'hA1B2);
        do_fill(7'h2E, 16'hC3D4);
        do_busy_op(8'h05, 7'h23, 1);
        lpm(7'h20, v); check("R4 low byte even", {8'h0, v}, 16'hB2);
        lpm(7'h21, v); check("R4 high byte odd", {8'h0, v}, 16'hA1);
        check_page("R5 page write", 3'd2);
        // R5 buffer cleared after write
        do_busy_op(8'h05, 7'h30, 0);
        check_page("R5 buffer cleared", 3'd3);

        // R6 erase via odd address inside page 2
        do_busy_op(8'h03, 7'h2F, 1);
        check_page("R6 page erase", 3'd2);

        // R7 stimulus ignored during busy
        arm(8'h03); spm(7'h50, 16'h0);
        arm(8'h01); spm(7'h60, 16'h1234);
        arm(8'h09); spm(7'h00, 16'h00C3);
        drain();
        info(8'h09, 7'h01, v); check("R7 lock untouched while busy", {8'h0, v}, 16'hFF);
        do_busy_op(8'h05, 7'h60, 0);
        lpm(7'h60, v); check("R7 fill ignored while busy", {8'h0, v}, 16'hFF);

        // R2 window: fourth edge accepted
        arm(8'h09); repeat (3) @(negedge clk); spm(7'h55, 16'hFFFB);
        m_lock = m_lock & 8'hFB;
        info(8'h09, 7'h01, v); check("R2 edge four accepted", {8'h0, v}, {8'h0, m_lock});
        // R2 fifth edge rejected
        arm(8'h09); repeat (4) @(negedge clk); spm(7'h00, 16'hFFF7);
        info(8'h09, 7'h01, v); check("R2 edge five rejected", {8'h0, v}, {8'h0, m_lock});

        // R3 arm consumed by one strobe
        arm(8'h09); spm(7'h01, 16'hFFF7); spm(7'h01, 16'hFFEF);
        m_lock = m_lock & 8'hF7;
        info(8'h09, 7'h01, v); check("R3 second strobe ignored", {8'h0, v}, {8'h0, m_lock});
        arm(8'h07); spm(7'h01, 16'h0000);
        spm(7'h01, 16'h0000);
        arm(8'h21); spm(7'h01, 16'h0000);
        arm(8'h09); arm(8'h44); spm(7'h01, 16'h0000);
        info(8'h09, 7'h01, v); check("R3 bad/no/mismatched arm", {8'h0, v}, {8'h0, m_lock});

        // R8 address ignored, fixed bits stay, no restore
        arm(8'h09); spm(7'h7F, 16'h00EF);
        m_lock = m_lock & 8'hEF;
        arm(8'h09); spm(7'h3A, 16'hFFFF);
        info(8'h09, 7'h01, v); check("R8 lock monotonic", {8'h0, v}, {8'h0, m_lock});
        check("R8 fixed bits", {8'h0, v & 8'hC3}, 16'h00C3);

        // R9 fuse map
        info(8'h09, 7'h00, v); check("R9 low fuse", {8'h0, v}, 16'h62);
        info(8'h09, 7'h02, v); check("R9 ext fuse", {8'h0, v}, 16'hFF);
        info(8'h09, 7'h03, v); check("R9 high fuse", {8'h0, v}, 16'hD9);

        // R10 signature row
        for (int i = 0; i < 32; i++) begin
            info(8'h21, 7'(i), v); check("R10 signature", {8'h0, v}, {8'h0, exp_sig(i)});
        end

        // R11 plain reads after lock programming and under non-read arm
        do_fill(7'h44, 16'h5A3C);
        do_busy_op(8'h05, 7'h40, 0);
        lpm(7'h44, v); check("R11 plain read after lock", {8'h0, v}, 16'h3C);
        arm(8'h01); lpm(7'h45, v); check("R11 read under fill arm", {8'h0, v}, 16'h5A);

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            logic [6:0] a;
            logic [15:0] d;
            op = int'($urandom_range(0, 5));
            a = 7'($urandom);
            d = 16'($urandom);
            case (op)
                0, 1: do_fill({a[6:1], 1'b0}, d);
                2: do_busy_op(8'h05, a, 1);
                3: do_busy_op(8'h03, a, 1);
                4: begin lpm(a, v); check("R11 random read", {8'h0, v}, {8'h0, exp_byte(a)}); end
                default: begin
                    arm(8'h09); spm(a, d);
                    m_lock = m_lock & {2'b11, d[5:2], 2'b11};
                    info(8'h09, 7'h01, v); check("R8 random lock", {8'h0, v}, {8'h0, m_lock});
                end
            endcase
        end
        for (int p = 0; p < 8; p++) check_page("R5 R6 random pages", 3'(p));

        // R12 chip erase, also during busy
        arm(8'h03); spm(7'h10, 16'h0);
        chip_erase = 1; @(negedge clk); chip_erase = 0;
        check("R12 busy aborted", {15'h0, busy}, 16'h0);
        for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF;
        for (int i = 0; i < 8; i++) m_buf[i] = 16'hFFFF;
        m_lock = 8'hFF;
        info(8'h09, 7'h01, v); check("R12 lock restored", {8'h0, v}, 16'hFF);
        for (int p = 0; p < 8; p++) check_page("R12 array erased", 3'(p));
        do_busy_op(8'h05, 7'h00, 0);
        check_page("R12 buffer erased", 3'd0);

        summary();
    end
endmodule